// File: doc/BRIEF.md
# Byte-to-Word DMA Data Packer

This block sits in the data path of a memory-to-peripheral DMA channel. A byte-wide source read stream comes in, and a 32-bit write stream goes out to one fixed destination address. The downstream consumer is typically a word-oriented engine such as a hash core, which only sees 32-bit words. The block makes sure that a byte buffer reaches that engine as the same word sequence a little-endian 32-bit processor store would produce.

A 2-bit alignment mode chooses between two behaviours. In the padding modes, each source byte becomes one output word. In pack mode, up to four consecutive bytes are gathered into a single word. An optional byte exchange and halfword exchange then reorder the lanes of the assembled word. A transfer starts with a start pulse that captures the mode, the exchange controls and a byte count. If the count is not a multiple of four, the final partial word is flushed. Input and output both use valid/ready handshakes, and a done pulse marks the end of the transfer.

Top module: `byte_word_packer`

## Requirements
- R1: After reset, `busy`, `in_ready`, `out_valid` and `done` are all 0.
- R2: A `start` pulse while idle with a nonzero `cfg_len` captures the configuration and the count, and makes `busy` high in the next cycle. A `start` with `cfg_len` of 0 is ignored: `busy` and `in_ready` stay 0. `in_ready` is never high while `busy` is low.
- R3: With `cfg_align` = 2'b00 or 2'b11, each accepted byte b yields one word {24'h0, b} with `out_mask` = 4'b0001, so N bytes give N words.
- R4: With `cfg_align` = 2'b01, each accepted byte b yields one word holding b sign-extended to 32 bits, with `out_mask` = 4'b0001.
- R5: With `cfg_align` = 2'b10, the bytes B0, B1, B2, B3, taken in arrival order, yield one word {B3,B2,B1,B0} (the first byte in bits 7:0) with `out_mask` = 4'b1111.
- R6: In pack mode, when `cfg_len` is not a multiple of 4, the last word holds its k remaining bytes in the low k lanes (lane i = bits 8i+7:8i) and zeros above. Its `out_mask` has bits k-1..0 set. A word with `out_valid` high never has an all-zero `out_mask`.
- R7: Exchange acts on both data and mask. Output lane i comes from pre-exchange lane i XOR {`cfg_half_xchg`,`cfg_byte_xchg`}. So byte exchange swaps the bytes within each halfword, halfword exchange swaps the two halfwords, and both together reverse the word. Exchange applies in every mode.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_mask` hold and `in_ready` is 0. Across a transfer, every byte appears in exactly one output word, in order, and no extra word is produced.
- R9: `done` is a one-cycle pulse in the cycle after the last word is accepted. `busy` is low in that same cycle.
- R10: Changing `cfg_align`, `cfg_byte_xchg`, `cfg_half_xchg`, `cfg_len` or pulsing `start` while `busy` is high has no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer with the present configuration |
| cfg_align | input | 2 | Alignment mode: 00/11 zero pad, 01 sign extend, 10 pack |
| cfg_byte_xchg | input | 1 | Swap the bytes inside each halfword of the output word |
| cfg_half_xchg | input | 1 | Swap the two halfwords of the output word |
| cfg_len | input | LEN_W | Transfer length in source bytes |
| in_valid | input | 1 | Source byte valid |
| in_data | input | 8 | Source byte |
| in_ready | output | 1 | Block accepts the source byte this cycle |
| out_valid | output | 1 | Destination word valid |
| out_data | output | 32 | Destination word |
| out_mask | output | 4 | Per-lane byte-valid mask of the destination word |
| out_ready | input | 1 | Destination accepts the word this cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the last word is accepted |

## Verification
The patterns are chosen so that each mode's mistakes show up in a different way:
- Padding runs use bytes with and without bit 7 set, which separates zero extension from sign extension.
- Pack runs use lengths of 16, 12, 9, 7, 6 and 1 bytes, so every partial-lane count appears in the flushed last word, along with whole-word multiples.
- Each exchange combination runs on both full and partial words, so a wrong lane permutation or an unpermuted mask shows up directly.
- Source gaps and destination stalls vary between runs to expose dropped, duplicated or reordered bytes and unstable held words.
- One run changes every configuration input and re-pulses start mid-transfer, to show the captured settings are kept.

// File: rtl/packer_pkg.sv
// Shared types for the byte-to-word packer.
// Assumes byte lanes of 8 bits and a 2-bit alignment mode field.
package packer_pkg;

    localparam int BYTE_W = 8;

    // Alignment mode; only PACK gathers several bytes per word.
    typedef enum logic [1:0] {
        ALIGN_ZPAD  = 2'b00,
        ALIGN_SEXT  = 2'b01,
        ALIGN_PACK  = 2'b10,
        ALIGN_ZPAD2 = 2'b11
    } align_e;

    // Configuration captured at transfer start.
    typedef struct packed {
        align_e align;
        logic   byte_xchg;
        logic   half_xchg;
    } pk_cfg_t;

endpackage

// File: rtl/packer_ctrl.sv
// Transfer control: captures configuration and byte count on start,
// counts accepted bytes down, and ends the transfer when the last word
// leaves. Assumes the final byte always completes a word.
module packer_ctrl
    import packer_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  pk_cfg_t          cfg_i,
    input  logic             byte_fire_i,
    input  logic             word_fire_i,
    output logic             launch_o,
    output logic             busy_o,
    output logic             bytes_left_o,
    output logic             last_byte_o,
    output logic             done_o,
    output pk_cfg_t          cfg_o
);

    logic [LEN_W-1:0] left_q;
    logic             busy_q;
    logic             done_q;
    pk_cfg_t          cfg_q;
    logic             finish;

    // Accept a start only when idle and the count is nonzero.
    assign launch_o = start_i && !busy_q && (len_i != '0);
    // The last word is accepted once no bytes remain.
    assign finish   = busy_q && word_fire_i && (left_q == '0);

    // Busy flag, byte countdown, captured configuration and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cfg_q  <= '{align: ALIGN_ZPAD, byte_xchg: 1'b0, half_xchg: 1'b0};
        end else begin
            done_q <= finish;
            if (launch_o) begin
                busy_q <= 1'b1;
                left_q <= len_i;
                cfg_q  <= cfg_i;
            end else begin
                if (finish)
                    busy_q <= 1'b0;
                if (byte_fire_i)
                    left_q <= left_q - 1'b1;
            end
        end
    end

    assign busy_o       = busy_q;
    assign bytes_left_o = (left_q != '0);
    assign last_byte_o  = (left_q == LEN_W'(1));
    assign done_o       = done_q;
    assign cfg_o        = cfg_q;

endmodule

// File: rtl/packer_lanes.sv
// Lane assembler: in pack mode it stores bytes in lane order and forms a
// word when the lanes are full or the transfer's last byte arrives; in the
// padding modes it forms one extended word per byte. Assumes LANES is a
// power of two and at most one byte arrives per cycle.
module packer_lanes
    import packer_pkg::*;
#(
    parameter int LANES = 4,
    parameter int LW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                byte_fire_i,
    input  logic [LW-1:0]       byte_i,
    input  align_e              align_i,
    input  logic                last_byte_i,
    output logic                word_load_o,
    output logic [LANES*LW-1:0] word_o,
    output logic [LANES-1:0]    mask_o
);

    localparam int IDX_W = $clog2(LANES);

    logic [LW-1:0]    acc_q [LANES];
    logic [IDX_W-1:0] idx_q;
    logic             pack;
    logic             full;
    logic [LW-1:0]    ext;

    assign pack        = (align_i == ALIGN_PACK);
    assign full        = (idx_q == IDX_W'(LANES - 1));
    assign ext         = (align_i == ALIGN_SEXT) ? {LW{byte_i[LW-1]}} : '0;
    assign word_load_o = byte_fire_i && (!pack || full || last_byte_i);

    // Per-lane selection of stored byte, incoming byte, extension or zero.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] pk_lane;
        logic          pk_bit;
        assign pk_lane = (IDX_W'(g) < idx_q)  ? acc_q[g] :
                         (IDX_W'(g) == idx_q) ? byte_i   : '0;
        assign pk_bit  = (IDX_W'(g) <= idx_q);
        if (g == 0) begin : g_low
            assign word_o[g*LW +: LW] = pack ? pk_lane : byte_i;
            assign mask_o[g]          = pack ? pk_bit  : 1'b1;
        end else begin : g_high
            assign word_o[g*LW +: LW] = pack ? pk_lane : ext;
            assign mask_o[g]          = pack ? pk_bit  : 1'b0;
        end
    end

    // Lane pointer and byte storage for partially assembled words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            for (int i = 0; i < LANES; i++)
                acc_q[i] <= '0;
        end else if (clear_i) begin
            idx_q <= '0;
        end else if (byte_fire_i) begin
            if (word_load_o) begin
                idx_q <= '0;
            end else begin
                acc_q[idx_q] <= byte_i;
                idx_q        <= idx_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/packer_xchg.sv
// Lane exchanger: output lane i takes input lane (i XOR sel). With four
// lanes, sel bit 0 swaps bytes in halfwords and bit 1 swaps halfwords.
// Applied identically to data and mask. Purely combinational.
module packer_xchg #(
    parameter int LANES = 4,
    parameter int LW    = 8,
    parameter int IDX_W = $clog2(LANES)
) (
    input  logic [LANES*LW-1:0] word_i,
    input  logic [LANES-1:0]    mask_i,
    input  logic [IDX_W-1:0]    sel_i,
    output logic [LANES*LW-1:0] word_o,
    output logic [LANES-1:0]    mask_o
);

    logic [LW-1:0] lane_in [LANES];

    // Unpack lanes, then route each output lane from its XOR partner.
    for (genvar g = 0; g < LANES; g++) begin : g_route
        assign lane_in[g]         = word_i[g*LW +: LW];
        assign word_o[g*LW +: LW] = lane_in[IDX_W'(g) ^ sel_i];
        assign mask_o[g]          = mask_i[IDX_W'(g) ^ sel_i];
    end

endmodule

// File: rtl/byte_word_packer.sv
// Byte-to-word DMA packer top. Accepts a ready/valid byte stream, forms
// 32-bit words per the captured alignment mode and exchange controls, and
// holds each word in a single output register until accepted. Assumes
// one byte per cycle at most; input stalls while a word waits.
module byte_word_packer
    import packer_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       cfg_align,
    input  logic             cfg_byte_xchg,
    input  logic             cfg_half_xchg,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data,
    output logic [OUT_W/8-1:0] out_mask,
    input  logic             out_ready,
    output logic             busy,
    output logic             done
);

    localparam int LANES = OUT_W / BYTE_W;
    localparam int IDX_W = $clog2(LANES);

    pk_cfg_t          cfg_in;
    pk_cfg_t          cfg_q;
    logic             launch;
    logic             bytes_left;
    logic             last_byte;
    logic             byte_fire;
    logic             word_fire;
    logic             word_load;
    logic [OUT_W-1:0] asm_word;
    logic [LANES-1:0] asm_mask;
    logic [OUT_W-1:0] xw_word;
    logic [LANES-1:0] xw_mask;
    logic [IDX_W-1:0] xsel;
    logic             ov_q;
    logic [OUT_W-1:0] od_q;
    logic [LANES-1:0] om_q;

    assign cfg_in = '{align: align_e'(cfg_align),
                      byte_xchg: cfg_byte_xchg,
                      half_xchg: cfg_half_xchg};

    assign in_ready  = busy && bytes_left && (!ov_q || out_ready);
    assign byte_fire = in_valid && in_ready;
    assign word_fire = ov_q && out_ready;
    assign xsel      = IDX_W'({cfg_q.half_xchg, cfg_q.byte_xchg});

    packer_ctrl #(.LEN_W(LEN_W)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .len_i        (cfg_len),
        .cfg_i        (cfg_in),
        .byte_fire_i  (byte_fire),
        .word_fire_i  (word_fire),
        .launch_o     (launch),
        .busy_o       (busy),
        .bytes_left_o (bytes_left),
        .last_byte_o  (last_byte),
        .done_o       (done),
        .cfg_o        (cfg_q)
    );

    packer_lanes #(.LANES(LANES), .LW(BYTE_W)) lanes_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (launch),
        .byte_fire_i (byte_fire),
        .byte_i      (in_data),
        .align_i     (cfg_q.align),
        .last_byte_i (last_byte),
        .word_load_o (word_load),
        .word_o      (asm_word),
        .mask_o      (asm_mask)
    );

    packer_xchg #(.LANES(LANES), .LW(BYTE_W), .IDX_W(IDX_W)) xchg_i (
        .word_i (asm_word),
        .mask_i (asm_mask),
        .sel_i  (xsel),
        .word_o (xw_word),
        .mask_o (xw_mask)
    );

    // Output word register: load on completion, clear when accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_q <= 1'b0;
            od_q <= '0;
            om_q <= '0;
        end else if (word_load) begin
            ov_q <= 1'b1;
            od_q <= xw_word;
            om_q <= xw_mask;
        end else if (out_ready) begin
            ov_q <= 1'b0;
        end
    end

    assign out_valid = ov_q;
    assign out_data  = od_q;
    assign out_mask  = om_q;

endmodule

// File: rtl/packer_checks.sv
// Protocol checker for the packer, attached to every instance by bind.
// Observes ports only.
module packer_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        out_valid,
    input logic [31:0] out_data,
    input logic [3:0]  out_mask,
    input logic        out_ready,
    input logic        busy,
    input logic        done
);

    assert_idle_no_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !in_ready);

    assert_hold_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_mask)));

    assert_stall_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    assert_done_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(out_valid && out_ready) && !busy));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_mask_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mask != 4'b0000));

endmodule

bind byte_word_packer packer_checks chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_mask  (out_mask),
    .out_ready (out_ready),
    .busy      (busy),
    .done      (done)
);

// File: tb/byte_word_packer_tb_top.sv
// Self-checking bench: a behavioural queue model predicts every output
// word and mask; a per-clock monitor compares handshakes, holds and done.
module byte_word_packer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cfg_align = 2'b00;
    logic        cfg_byte_xchg = 1'b0;
    logic        cfg_half_xchg = 1'b0;
    logic [15:0] cfg_len = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [31:0] out_data;
    logic [3:0]  out_mask;
    logic        out_ready = 1'b1;
    logic        busy;
    logic        done;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int stall_mode = 0;
    bit finished = 0;
    bit done_seen = 0;
    bit expect_done = 0;
    bit hold_prev = 0;
    logic [31:0] held_data;
    logic [3:0]  held_mask;
    logic [15:0] lfsr = 16'hACE1;
    int seed = 1;
    string cur_tag = "R1";

    logic [7:0]  src [64];
    logic [31:0] exp_w [$];
    logic [3:0]  exp_m [$];

    always #2 clk = ~clk;

    byte_word_packer dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_align(cfg_align), .cfg_byte_xchg(cfg_byte_xchg),
        .cfg_half_xchg(cfg_half_xchg), .cfg_len(cfg_len),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_mask(out_mask),
        .out_ready(out_ready), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    // Build the expected word/mask sequence from the byte list.
    task automatic model_words(input logic [1:0] m, input logic bx, input logic hx, input int n);
        int i = 0;
        while (i < n) begin
            logic [31:0] w;
            logic [3:0]  mk;
            w = '0; mk = '0;
            if (m == 2'b10) begin
                int k = (n - i < 4) ? n - i : 4;
                for (int j = 0; j < k; j++) begin
                    w[8*j +: 8] = src[i + j];
                    mk[j] = 1'b1;
                end
                i += k;
            end else begin
                w = (m == 2'b01) ? {{24{src[i][7]}}, src[i]} : {24'h0, src[i]};
                mk = 4'b0001;
                i++;
            end
            if (bx) begin
                w  = {w[23:16], w[31:24], w[7:0], w[15:8]};
                mk = {mk[2], mk[3], mk[0], mk[1]};
            end
            if (hx) begin
                w  = {w[15:0], w[31:16]};
                mk = {mk[1:0], mk[3:2]};
            end
            exp_w.push_back(w);
            exp_m.push_back(mk);
        end
    endtask

    // Destination ready pattern, changed just after each rising edge.
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (stall_mode)
            0: out_ready = 1'b1;
            1: out_ready = lfsr[3];
            default: out_ready = (cyc % 5) == 4;
        endcase
    end

    // Per-clock monitor, sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_prev) begin
                check(out_valid && out_data == held_data && out_mask == held_mask,
                      "R8", "held word", out_data, held_data);
            end
            if (out_valid && !out_ready)
                check(!in_ready, "R8", "in_ready while stalled", 32'(in_ready), 32'd0);
            if (expect_done || done) begin
                check(done == expect_done, "R9", "done pulse", 32'(done), 32'(expect_done));
                if (done)
                    check(!busy, "R9", "busy with done", 32'(busy), 32'd0);
            end
            if (done) done_seen = 1;
            expect_done = 0;
            if (out_valid && out_ready) begin
                if (exp_w.size() == 0) begin
                    check(0, "R8", "extra word", out_data, 32'h0);
                end else begin
                    logic [31:0] ew;
                    logic [3:0]  em;
                    ew = exp_w.pop_front();
                    em = exp_m.pop_front();
                    check(out_data == ew, cur_tag, "word", out_data, ew);
                    check(out_mask == em, cur_tag, "mask", 32'(out_mask), 32'(em));
                    if (exp_w.size() == 0) expect_done = 1;
                end
            end
            hold_prev = out_valid && !out_ready;
            held_data = out_data;
            held_mask = out_mask;
        end
    end

    // Run one transfer; poke changes config and re-pulses start mid-run.
    task automatic run_xfer(input logic [1:0] m, input logic bx, input logic hx,
                            input int n, input bit gaps, input int stall,
                            input string tag, input bit poke);
        int idx = 0;
        int t = 0;
        seed++;
        for (int i = 0; i < 64; i++)
            src[i] = 8'((seed * 53 + i * 71 + 3) & 255);
        model_words(m, bx, hx, n);
        cur_tag = tag;
        stall_mode = stall;
        done_seen = 0;
        @(posedge clk); #1;
        cfg_align = m; cfg_byte_xchg = bx; cfg_half_xchg = hx;
        cfg_len = 16'(n); start = 1'b1;
        @(negedge clk);
        @(posedge clk); #1;
        start = 1'b0;
        check(busy, "R2", "busy after start", 32'(busy), 32'd1);
        while (idx < n) begin
            if (gaps && lfsr[5]) begin
                in_valid = 1'b0;
            end else begin
                in_valid = 1'b1;
                in_data = src[idx];
            end
            if (poke && idx == 2) begin
                cfg_align = ~m; cfg_byte_xchg = ~bx; cfg_half_xchg = ~hx;
                cfg_len = 16'd3; start = 1'b1;
            end
            @(negedge clk);
            if (in_valid && in_ready) idx++;
            @(posedge clk); #1;
            start = 1'b0;
        end
        in_valid = 1'b0;
        while (!done_seen && t < 2000) begin
            @(negedge clk);
            t++;
        end
        check(done_seen, tag, "transfer completed", 32'(done_seen), 32'd1);
        check(exp_w.size() == 0, tag, "words outstanding", 32'(exp_w.size()), 32'd0);
        stall_mode = 0;
        repeat (3) @(negedge clk);
        check(exp_w.size() == 0 && !busy, "R8", "no extra word after done",
              32'(exp_w.size()), 32'd0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired got=%0d exp=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !in_ready && !out_valid && !done, "R1", "reset state",
              {28'h0, busy, in_ready, out_valid, done}, 32'h0);
        // R2 zero-length start is ignored
        @(posedge clk); #1;
        cfg_len = '0; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (2) @(negedge clk);
        check(!busy && !in_ready, "R2", "zero-length start", 32'(busy), 32'd0);

        run_xfer(2'b00, 0, 0, 6, 0, 0, "R3", 0);
        run_xfer(2'b11, 0, 0, 5, 1, 1, "R3", 0);
        run_xfer(2'b01, 0, 0, 8, 0, 2, "R4", 0);
        run_xfer(2'b10, 0, 0, 16, 0, 0, "R5", 0);
        run_xfer(2'b10, 0, 0, 12, 1, 1, "R5", 0);
        run_xfer(2'b10, 0, 0, 7, 0, 2, "R6", 0);
        run_xfer(2'b10, 0, 0, 1, 0, 0, "R6", 0);
        run_xfer(2'b10, 0, 0, 6, 1, 1, "R6", 0);
        run_xfer(2'b10, 1, 0, 8, 0, 0, "R7", 0);
        run_xfer(2'b10, 0, 1, 8, 1, 2, "R7", 0);
        run_xfer(2'b10, 1, 1, 6, 0, 1, "R7", 0);
        run_xfer(2'b01, 0, 1, 3, 0, 0, "R7", 0);
        run_xfer(2'b10, 0, 0, 9, 1, 1, "R10", 1);
        run_xfer(2'b00, 1, 0, 5, 0, 2, "R10", 1);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule